// File: doc/BRIEF.md
# Memory Region Security Guard

The guard sits beside a memory controller and classifies every access by whether it lands in secure memory. Eight programmable windows, each described by a first and a last megabyte index, can each be marked secure or non-secure and switched on or off. Any address that no enabled window covers falls into a single default window, which has its own secure flag. A global bypass forces every access to be treated as non-secure, whatever the windows hold. After reset the bypass is on and every window is off, so all of memory is open.

Software programs the guard through a bank of 16-bit configuration registers. Each write is a 32-bit word. The upper half is a per-bit write-enable mask for the lower half, so a single field can be changed without reading the register first. For each access the guard produces, one cycle later, a hit flag, the resolved secure attribute and a violation pulse. The violation pulse fires when a non-secure requester touches secure memory.

Top module: `mem_region_guard`

## Requirements
- R1: While reset is held and after its release with no writes, every access reports no hit, non-secure and no violation; reset leaves every window disabled, the default window non-secure and the bypass set.
- R2: An access presented with `acc_valid` high at a clock edge produces `rsp_valid` and its result on the next edge. When no access was presented, `rsp_valid`, `rsp_hit`, `rsp_secure` and `rsp_violation` are all low.
- R3: For a write, bit 16+k of `cfg_wdata` enables the write of bit k. A lower bit whose enable is 0 keeps its old value, and a write with an all-zero mask changes nothing.
- R4: Window n uses configuration index 6+2n for its first megabyte in bits [MB_W-1:0], its secure-select in bit 14 and its enable in bit 15, and index 7+2n for its last megabyte in bits [MB_W-1:0]. Index 21 also carries the default-window secure flag in bit 14 and the bypass in bit 15. Writes to any index below 6 or above 21 change nothing.
- R5: An address lies in window n when first_n <= addr[ADDR_W-1:20] <= last_n, with both bounds included. First 0 and last 0 cover exactly bytes 0x0 to 0xFFFFF.
- R6: A window whose enable bit is 0 never matches.
- R7: When several enabled windows match, the lowest-numbered one sets the attribute, whether it is secure or non-secure.
- R8: An access that matches no enabled window reports no hit and takes the default window's secure flag as its attribute.
- R9: While the bypass is set, every access is reported non-secure with no violation. The hit flag still reflects window matching. Clearing the bypass restores normal checking.
- R10: A non-secure access (`acc_secure`=0) whose resolved attribute is secure raises `rsp_violation` for that one response. A secure access never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_BITS (5) | Configuration register index |
| cfg_wdata | input | 32 | Upper half write-enable mask, lower half data |
| acc_valid | input | 1 | An access address is presented |
| acc_addr | input | ADDR_W (32) | Byte address of the access |
| acc_secure | input | 1 | Requester is secure |
| rsp_valid | output | 1 | Result for the access of the previous cycle |
| rsp_hit | output | 1 | Access matched an enabled window |
| rsp_secure | output | 1 | Resolved attribute is secure |
| rsp_violation | output | 1 | Non-secure access to secure memory, blocked |

## Verification
The assertions take for granted that every control input (`cfg_we`, `acc_valid`, `acc_secure`) holds a defined 0 or 1 from reset release onward. They also assume that the previous cycle's bypass value is the one that governs the current response. The stimulus drives every input from time zero and changes inputs only on the falling edge. It never places a configuration write in the same cycle as an access that depends on it, so every observed attribute reflects a settled configuration.

// File: rtl/mrg_pkg.sv
package mrg_pkg;
    localparam int REG_W     = 16;
    localparam int MB_SHIFT  = 20;
    localparam int SEL_BIT   = 14;
    localparam int EN_BIT    = 15;
    localparam int CATCH_BIT = 14;
    localparam int BYP_BIT   = 15;

    typedef struct packed {
        logic valid;
        logic hit;
        logic secure;
        logic violation;
    } rsp_t;
endpackage

// File: rtl/mrg_cfg_bank.sv
module mrg_cfg_bank
    import mrg_pkg::*;
#(
    parameter int NUM_RGN  = 8,
    parameter int MB_W     = 12,
    parameter int CFG_BASE = 6,
    parameter int IDX_BITS = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [IDX_BITS-1:0]            cfg_idx,
    input  logic [31:0]                    cfg_wdata,
    output logic [NUM_RGN-1:0][MB_W-1:0]   rgn_first,
    output logic [NUM_RGN-1:0][MB_W-1:0]   rgn_last,
    output logic [NUM_RGN-1:0]             rgn_sel,
    output logic [NUM_RGN-1:0]             rgn_en,
    output logic                           dflt_secure,
    output logic                           bypass
);
    localparam int NUM_REGS = 2 * NUM_RGN;
    localparam int LAST     = NUM_REGS - 1;
    localparam logic [IDX_BITS-1:0] IDX_LO = IDX_BITS'(CFG_BASE);
    localparam logic [IDX_BITS-1:0] IDX_HI = IDX_BITS'(CFG_BASE + NUM_REGS - 1);
    localparam logic [NUM_REGS*REG_W-1:0] RST_FLAT =
        (NUM_REGS*REG_W)'(1) << (LAST*REG_W + BYP_BIT);

    typedef struct packed {
        logic [NUM_REGS-1:0][REG_W-1:0] regs;
    } bank_t;

    bank_t              st_d, st_q;
    logic               in_map;
    logic [IDX_BITS-1:0] rel;
    logic [REG_W-1:0]   wmask, wval;

    always_comb begin
        st_d   = st_q;
        wmask  = cfg_wdata[31:16];
        wval   = cfg_wdata[15:0];
        in_map = (cfg_idx >= IDX_LO) && (cfg_idx <= IDX_HI);
        rel    = cfg_idx - IDX_LO;
        if (cfg_we && in_map) begin
            for (int r = 0; r < NUM_REGS; r++) begin
                if (rel == IDX_BITS'(r))
                    st_d.regs[r] = (st_q.regs[r] & ~wmask) | (wval & wmask);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= bank_t'(RST_FLAT);
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NUM_RGN; g++) begin : g_fields
        assign rgn_first[g] = st_q.regs[2*g][MB_W-1:0];
        assign rgn_sel[g]   = st_q.regs[2*g][SEL_BIT];
        assign rgn_en[g]    = st_q.regs[2*g][EN_BIT];
        assign rgn_last[g]  = st_q.regs[2*g+1][MB_W-1:0];
    end

    assign dflt_secure = st_q.regs[LAST][CATCH_BIT];
    assign bypass      = st_q.regs[LAST][BYP_BIT];

    AST_ZERO_MASK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && (cfg_wdata[31:16] == '0) |=> $stable(st_q)); // R3
    AST_NO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(st_q)); // R3
    AST_OFF_MAP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && ((cfg_idx < IDX_LO) || (cfg_idx > IDX_HI)) |=> $stable(st_q)); // R4
endmodule

// File: rtl/mrg_rgn_cmp.sv
module mrg_rgn_cmp #(
    parameter int MB_W = 12
) (
    input  logic [MB_W-1:0] acc_mb,
    input  logic [MB_W-1:0] first_mb,
    input  logic [MB_W-1:0] last_mb,
    input  logic            enable,
    output logic            match
);
    logic above_first, below_last;

    always_comb begin
        above_first = (acc_mb >= first_mb);
        below_last  = (acc_mb <= last_mb);
        match       = enable && above_first && below_last;
    end
endmodule

// File: rtl/mrg_resolve.sv
module mrg_resolve
    import mrg_pkg::*;
#(
    parameter int NUM_RGN = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic               acc_secure,
    input  logic [NUM_RGN-1:0] match,
    input  logic [NUM_RGN-1:0] rgn_sel,
    input  logic               dflt_secure,
    input  logic               bypass,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic               rsp_secure,
    output logic               rsp_violation
);
    rsp_t rsp_d, rsp_q;
    logic any_d, attr_d;

    always_comb begin
        any_d  = 1'b0;
        attr_d = dflt_secure;
        for (int i = NUM_RGN - 1; i >= 0; i--) begin
            if (match[i]) begin
                any_d  = 1'b1;
                attr_d = rgn_sel[i];
            end
        end
        rsp_d.valid     = acc_valid;
        rsp_d.hit       = acc_valid && any_d;
        rsp_d.secure    = acc_valid && !bypass && attr_d;
        rsp_d.violation = rsp_d.secure && !acc_secure;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid     = rsp_q.valid;
    assign rsp_hit       = rsp_q.hit;
    assign rsp_secure    = rsp_q.secure;
    assign rsp_violation = rsp_q.violation;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> rsp_valid); // R2
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !rsp_valid); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_hit && !rsp_secure && !rsp_violation); // R2
    AST_BYPASS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> !rsp_secure && !rsp_violation); // R9
    AST_VIOL_NEEDS_SECURE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_violation |-> rsp_secure && rsp_valid); // R10
    AST_SECURE_NEVER_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_secure |=> !rsp_violation); // R10
endmodule

// File: rtl/mem_region_guard.sv
module mem_region_guard
    import mrg_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int NUM_RGN  = 8,
    parameter int CFG_BASE = 6,
    parameter int IDX_BITS = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [IDX_BITS-1:0] cfg_idx,
    input  logic [31:0]         cfg_wdata,
    input  logic                acc_valid,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic                acc_secure,
    output logic                rsp_valid,
    output logic                rsp_hit,
    output logic                rsp_secure,
    output logic                rsp_violation
);
    localparam int MB_W = ADDR_W - MB_SHIFT;

    logic [NUM_RGN-1:0][MB_W-1:0] rgn_first, rgn_last;
    logic [NUM_RGN-1:0]           rgn_sel, rgn_en, match;
    logic                         dflt_secure, bypass;
    logic [MB_W-1:0]              acc_mb;
    logic                         unused_low;

    assign acc_mb     = acc_addr[ADDR_W-1:MB_SHIFT];
    assign unused_low = ^acc_addr[MB_SHIFT-1:0];

    mrg_cfg_bank #(
        .NUM_RGN (NUM_RGN),
        .MB_W    (MB_W),
        .CFG_BASE(CFG_BASE),
        .IDX_BITS(IDX_BITS)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_idx    (cfg_idx),
        .cfg_wdata  (cfg_wdata),
        .rgn_first  (rgn_first),
        .rgn_last   (rgn_last),
        .rgn_sel    (rgn_sel),
        .rgn_en     (rgn_en),
        .dflt_secure(dflt_secure),
        .bypass     (bypass)
    );

    for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
        mrg_rgn_cmp #(.MB_W(MB_W)) u_cmp (
            .acc_mb  (acc_mb),
            .first_mb(rgn_first[g]),
            .last_mb (rgn_last[g]),
            .enable  (rgn_en[g]),
            .match   (match[g])
        );
    end

    mrg_resolve #(.NUM_RGN(NUM_RGN)) u_resolve (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_valid    (acc_valid),
        .acc_secure   (acc_secure),
        .match        (match),
        .rgn_sel      (rgn_sel),
        .dflt_secure  (dflt_secure),
        .bypass       (bypass),
        .rsp_valid    (rsp_valid),
        .rsp_hit      (rsp_hit),
        .rsp_secure   (rsp_secure),
        .rsp_violation(rsp_violation)
    );
endmodule

// File: tb/sim_mem_region_guard.sv
module sim_mem_region_guard;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_secure = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_secure, rsp_violation;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_region_guard u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_secure(acc_secure), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_secure(rsp_secure), .rsp_violation(rsp_violation)
    );

    function automatic logic [31:0] mb(int m);
        return 32'(m) << 20;
    endfunction

    function automatic logic [31:0] outs();
        return 32'({rsp_valid, rsp_hit, rsp_secure, rsp_violation});
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(int idx, logic [31:0] data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_idx   = 5'(idx);
        cfg_wdata = data;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // expected word: {valid, hit, secure, violation}
    task automatic probe(logic [31:0] addr, logic sec, logic [3:0] exp, string req);
        @(negedge clk);
        acc_valid  = 1'b1;
        acc_addr   = addr;
        acc_secure = sec;
        @(negedge clk);
        check(req, outs(), 32'(exp));
        acc_valid  = 1'b0;
    endtask

    task automatic t_reset();
        acc_valid = 1'b1;
        acc_addr  = mb(0);
        #(CLK_PERIOD*3);
        check("R1 outputs in reset", outs(), 32'h0);
        acc_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        probe(mb(0), 1'b0, 4'b1000, "R1 open after reset");
        probe(mb(16), 1'b0, 4'b1000, "R1 no window enabled");
    endtask

    task automatic t_basic();
        wr(21, 32'h8000_0000);           // clear bypass
        wr(6,  32'h0FFF_0010);           // window 0 first MB 0x010
        wr(7,  32'h0FFF_001F);           // last MB 0x01F
        wr(6,  32'h4000_4000);           // select secure
        wr(6,  32'h8000_8000);           // enable
        probe(mb(16), 1'b0, 4'b1111, "R5 lower bound / R10 violation");
        probe(mb(31) | 32'hF_FFFF, 1'b0, 4'b1111, "R5 upper bound inclusive");
        probe(mb(15) | 32'hF_FFFF, 1'b0, 4'b1000, "R5 below first");
        probe(mb(32), 1'b0, 4'b1000, "R5 above last");
        probe(mb(20), 1'b1, 4'b1110, "R10 secure access allowed");
    endtask

    task automatic t_mask();
        wr(6, 32'h0001_0001);            // only bit 0: first becomes 0x011
        probe(mb(16), 1'b0, 4'b1000, "R3 masked field update");
        probe(mb(17), 1'b0, 4'b1111, "R3 control bits kept");
        wr(6, 32'h0000_0000);            // zero mask
        probe(mb(17), 1'b0, 4'b1111, "R3 zero mask no change");
        probe(mb(16), 1'b0, 4'b1000, "R3 zero mask no change low");
        wr(6, 32'h0001_0000);            // restore first 0x010
        probe(mb(16), 1'b0, 4'b1111, "R3 restore");
    endtask

    task automatic t_single_mb();
        wr(8, 32'hCFFF_C000);
        wr(9, 32'h0FFF_0000);
        probe(32'h000F_FFFF, 1'b0, 4'b1111, "R5 single MB top byte");
        probe(32'h0000_0000, 1'b0, 4'b1111, "R5 single MB byte 0");
        probe(32'h0010_0000, 1'b0, 4'b1000, "R5 single MB next MB");
    endtask

    task automatic t_disabled();
        wr(10, 32'hFFFF_4100);           // selected, not enabled
        wr(11, 32'h0FFF_0100);
        probe(mb(256), 1'b0, 4'b1000, "R6 disabled no match");
        wr(10, 32'h8000_8000);
        probe(mb(256), 1'b0, 4'b1111, "R6 enabled matches");
        wr(10, 32'h8000_0000);
        probe(mb(256), 1'b0, 4'b1000, "R6 disabled again");
    endtask

    task automatic t_priority();
        wr(12, 32'hFFFF_8200);           // w3 non-secure 0x200..0x20F
        wr(13, 32'h0FFF_020F);
        wr(14, 32'hFFFF_C205);           // w4 secure 0x205..0x2FF
        wr(15, 32'h0FFF_02FF);
        probe(mb(32'h208), 1'b0, 4'b1100, "R7 lower non-secure wins");
        probe(mb(32'h210), 1'b0, 4'b1111, "R7 only upper window");
        wr(16, 32'hFFFF_C300);           // w5 secure 0x300..0x30F
        wr(17, 32'h0FFF_030F);
        wr(18, 32'hFFFF_8300);           // w6 non-secure 0x300..0x3FF
        wr(19, 32'h0FFF_03FF);
        probe(mb(32'h305), 1'b0, 4'b1111, "R7 lower secure wins");
        probe(mb(32'h310), 1'b0, 4'b1100, "R7 only w6");
    endtask

    task automatic t_default();
        wr(21, 32'h4000_4000);
        probe(mb(32'h800), 1'b0, 4'b1011, "R8 default secure");
        probe(mb(32'h800), 1'b1, 4'b1010, "R8 default secure access");
        probe(mb(32'h208), 1'b0, 4'b1100, "R8 window overrides default");
        wr(21, 32'h4000_0000);
        probe(mb(32'h800), 1'b0, 4'b1000, "R8 default non-secure");
    endtask

    task automatic t_bypass();
        wr(21, 32'h8000_8000);
        probe(mb(16), 1'b0, 4'b1100, "R9 bypass keeps hit, no secure");
        probe(mb(32'h305), 1'b0, 4'b1100, "R9 bypass other window");
        wr(21, 32'h8000_0000);
        probe(mb(16), 1'b0, 4'b1111, "R9 bypass cleared");
    endtask

    task automatic t_map();
        wr(22, 32'hFFFF_0000);
        wr(4,  32'hFFFF_FFFF);
        wr(5,  32'hFFFF_FFFF);
        wr(31, 32'hFFFF_FFFF);
        probe(mb(16), 1'b0, 4'b1111, "R4 window 0 untouched");
        probe(mb(32'h800), 1'b0, 4'b1000, "R4 default and bypass untouched");
        wr(20, 32'hFFFF_CA00);           // w7 first 0xA00
        wr(21, 32'h0FFF_0A0F);           // w7 last in shared register
        probe(mb(32'hA0F), 1'b0, 4'b1111, "R4 window 7 last bound");
        probe(mb(32'hA10), 1'b0, 4'b1000, "R4 window 7 above last");
    endtask

    task automatic t_latency();
        @(negedge clk);
        acc_valid  = 1'b1;
        acc_addr   = mb(16);
        acc_secure = 1'b0;
        #1;
        check("R2 no result before edge", 32'(rsp_valid), 32'h0);
        @(negedge clk);
        check("R2 first result", outs(), 32'hF);
        acc_addr   = mb(32'h800);
        acc_secure = 1'b1;
        @(negedge clk);
        check("R2 back-to-back result", outs(), 32'h8);
        acc_valid  = 1'b0;
        @(negedge clk);
        check("R2 idle quiet", outs(), 32'h0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_mask();
        t_single_mb();
        t_disabled();
        t_priority();
        t_default();
        t_bypass();
        t_map();
        t_latency();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule